// File: doc/BRIEF.md
# Monochrome Text-Adapter Init Sequencer

This block brings a monochrome text display adapter, built around a 6845-class CRT controller, into its 80-column text mode. It does this without software after reset. It sits in front of a bus cycle generator and hands that generator one I/O write at a time, on a simple request/done interface. It waits for each write to finish before it starts the next one. Once the last write is done, it raises an init-complete flag.

The sequence is fixed. After a settle delay, set by a parameter, the adapter's mode port is written first. All sixteen controller registers are then loaded as index/data pairs, going from the highest register number down to register 0. The settle delay keeps glitches on the bus lines after reset away from the card. A start pulse re-runs the whole sequence, delay included, but only once the previous run has finished.

Top module: `crtc_init_seq`

## Requirements
- R1: While `rst` is high, and for the first `SETTLE_CYCLES` rising clock edges after it falls, `wr_req_o` and `init_done_o` are low. `wr_req_o` is first seen high after edge number `SETTLE_CYCLES`.
- R2: The first write of every run goes to I/O address 3B8h with data 29h. This value turns on high resolution, video output and blinking.
- R3: Each controller register takes two writes. The first sends the register number as data to index address 3B4h. The second sends the register's value to data address 3B5h.
- R4: The register numbers in the index writes run from 15 down to 0, one per pair.
- R5: Registers 0 to 15 receive 61h, 50h, 52h, 0Fh, 19h, 06h, 19h, 19h, 02h, 0Dh, 0Bh, 0Ch, 00h, 00h, 00h, 00h.
- R6: A run consists of exactly 33 write requests. `wr_io_o` is 1, meaning I/O space, on every one, so no memory cycle is ever requested.
- R7: While `wr_req_o` is high, `wr_addr_o` and `wr_data_o` hold steady until a cycle in which `wr_done_i` is high. `wr_req_o` is low in the following cycle, and the next request starts one cycle after that.
- R8: `wr_done_i` has no effect when no request is pending.
- R9: `init_done_o` rises in the cycle after the done of the last data write (3B5h, 61h). It then stays high, with `wr_req_o` low, until a start is accepted.
- R10: A `start_i` pulse while `init_done_o` is high drops `init_done_o` in the next cycle. The full sequence then runs again, settle delay included.
- R11: A `start_i` pulse while a run is in progress is ignored. That run still makes exactly 33 writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Re-run request, accepted only after completion |
| wr_done_i | input | 1 | Current write finished (from the bus cycle generator) |
| wr_req_o | output | 1 | Write request pending |
| wr_io_o | output | 1 | Address space of the request: 1 = I/O, 0 = memory |
| wr_addr_o | output | 12 | Write address |
| wr_data_o | output | 8 | Write data |
| init_done_o | output | 1 | Sequence complete |

## Verification
The assertions assume that `wr_done_i` is meaningful only while a request is pending. They do not assume it is a single-cycle pulse or that it is low while idle. They also assume `start_i` may arrive at any time. The stimulus answers requests after latencies of zero to three cycles. In one run it holds `wr_done_i` high for the whole time no request is pending. It also fires start pulses both after completion and in the middle of a run. A behavioural model in the bench predicts every output on every clock across all of these cases.

// File: rtl/crtc_init_pkg.sv
package crtc_init_pkg;

    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned NUM_REGS   = 16;
    localparam int unsigned REG_IDX_W  = $clog2(NUM_REGS);
    localparam int unsigned STEP_COUNT = 1 + 2 * NUM_REGS;
    localparam int unsigned STEP_W     = $clog2(STEP_COUNT);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_COUNT - 1);

    localparam logic [ADDR_W-1:0] PORT_MODE  = 12'h3B8;
    localparam logic [ADDR_W-1:0] PORT_INDEX = 12'h3B4;
    localparam logic [ADDR_W-1:0] PORT_VALUE = 12'h3B5;
    localparam logic [DATA_W-1:0] MODE_WORD  = 8'h29;

    typedef enum logic [1:0] {
        SQ_SETTLE   = 2'd0,
        SQ_ISSUE    = 2'd1,
        SQ_GAP      = 2'd2,
        SQ_COMPLETE = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic              io_space;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    // Text-mode timing value for one controller register.
    function automatic logic [DATA_W-1:0] reg_value(input logic [REG_IDX_W-1:0] r);
        logic [DATA_W-1:0] v;
        case (r)
            4'd0:    v = 8'h61;
            4'd1:    v = 8'h50;
            4'd2:    v = 8'h52;
            4'd3:    v = 8'h0F;
            4'd4:    v = 8'h19;
            4'd5:    v = 8'h06;
            4'd6:    v = 8'h19;
            4'd7:    v = 8'h19;
            4'd8:    v = 8'h02;
            4'd9:    v = 8'h0D;
            4'd10:   v = 8'h0B;
            4'd11:   v = 8'h0C;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Step 0 is the mode port; step k>0 belongs to pair (k-1)/2, index first.
    function automatic wr_cmd_t decode_step(input logic [STEP_W-1:0] s);
        wr_cmd_t              c;
        logic [STEP_W-1:0]    k;
        logic [REG_IDX_W-1:0] pair;
        logic [REG_IDX_W-1:0] regno;
        k        = s - STEP_W'(1);
        pair     = k[REG_IDX_W:1];
        regno    = REG_IDX_W'(NUM_REGS - 1) - pair;
        c.io_space = 1'b1;
        if (s == '0) begin
            c.addr = PORT_MODE;
            c.data = MODE_WORD;
        end else if (!k[0]) begin
            c.addr = PORT_INDEX;
            c.data = DATA_W'(regno);
        end else begin
            c.addr = PORT_VALUE;
            c.data = reg_value(regno);
        end
        return c;
    endfunction

endpackage

// File: rtl/crtc_settle_timer.sv
module crtc_settle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            cnt_q <= LOAD;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = run && (cnt_q == '0);

endmodule

// File: rtl/crtc_step_decoder.sv
module crtc_step_decoder
    import crtc_init_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output wr_cmd_t           cmd
);
    always_comb begin
        cmd = decode_step(step);
    end
endmodule

// File: rtl/crtc_init_fsm.sv
module crtc_init_fsm
    import crtc_init_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_done_i,
    output logic              req,
    output logic [STEP_W-1:0] step,
    output logic              complete
);
    sq_state_e         state_q;
    logic [STEP_W-1:0] step_q;
    logic              complete_q;
    logic              accept_start;
    logic              settle_run;
    logic              settle_expired;

    assign accept_start = (state_q == SQ_COMPLETE) && start_i;
    assign settle_run   = (state_q == SQ_SETTLE);

    crtc_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .reload  (accept_start),
        .run     (settle_run),
        .expired (settle_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_SETTLE;
            step_q     <= '0;
            complete_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_SETTLE: begin
                    if (settle_expired) state_q <= SQ_ISSUE;
                end
                SQ_ISSUE: begin
                    if (wr_done_i) begin
                        if (step_q == LAST_STEP) begin
                            state_q    <= SQ_COMPLETE;
                            complete_q <= 1'b1;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            state_q <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    state_q <= SQ_ISSUE;
                end
                default: begin
                    if (accept_start) begin
                        state_q    <= SQ_SETTLE;
                        step_q     <= '0;
                        complete_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign req      = (state_q == SQ_ISSUE);
    assign step     = step_q;
    assign complete = complete_q;

endmodule

// File: rtl/crtc_init_seq.sv
module crtc_init_seq
    import crtc_init_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_done_i,
    output logic              wr_req_o,
    output logic              wr_io_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              init_done_o
);
    logic [STEP_W-1:0] step;
    wr_cmd_t           cmd;

    crtc_init_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .wr_done_i (wr_done_i),
        .req       (wr_req_o),
        .step      (step),
        .complete  (init_done_o)
    );

    crtc_step_decoder u_dec (
        .step (step),
        .cmd  (cmd)
    );

    assign wr_io_o   = cmd.io_space;
    assign wr_addr_o = cmd.addr;
    assign wr_data_o = cmd.data;

endmodule

// File: rtl/crtc_init_seq_chk.sv
module crtc_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        wr_done_i,
    input logic        wr_req_o,
    input logic        wr_io_o,
    input logic [11:0] wr_addr_o,
    input logic [7:0]  wr_data_o,
    input logic        init_done_o
);
    // R7
    hold_until_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o && !wr_done_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

    // R7
    drop_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o && wr_done_i |=> !wr_req_o);

    // R6
    io_space_only_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> wr_io_o);

    // R9
    idle_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> !wr_req_o);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> $past(wr_req_o && wr_done_i && wr_addr_o == 12'h3B5 && wr_data_o == 8'h61));

    // R10
    fall_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(init_done_o) |-> $past(start_i));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done_o && !start_i |=> init_done_o);
endmodule

bind crtc_init_seq crtc_init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .wr_done_i   (wr_done_i),
    .wr_req_o    (wr_req_o),
    .wr_io_o     (wr_io_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .init_done_o (init_done_o)
);

// File: tb/test_crtc_init_seq.sv
module test_crtc_init_seq;
    localparam int SETTLE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        wr_done_i = 1'b0;
    logic        wr_req_o;
    logic        wr_io_o;
    logic [11:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        init_done_o;

    int compared = 0;
    int mismatched = 0;
    int lat = 0;
    int lat_cnt = 0;
    bit noise = 0;
    int writes = 0;
    bit prev_req = 0;
    int cycles = 0;

    // Values indexed by position in the load order (register 15 first).
    logic [7:0] vals_desc [16] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h0C, 8'h0B, 8'h0D, 8'h02,
                                   8'h19, 8'h19, 8'h06, 8'h19, 8'h0F, 8'h52, 8'h50, 8'h61};

    // Reference model: 0 settle, 1 writing, 2 idle gap, 3 finished
    int m_phase = 0;
    int m_cnt = 0;
    int m_step = 0;
    bit m_done = 0;

    crtc_init_seq #(.SETTLE_CYCLES(SETTLE)) i_crtc_init_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .wr_done_i(wr_done_i),
        .wr_req_o(wr_req_o), .wr_io_o(wr_io_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .init_done_o(init_done_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_step = 0; m_done = 0;
        end else begin
            case (m_phase)
                0: begin
                    m_cnt++;
                    if (m_cnt == SETTLE) m_phase = 1;
                end
                1: if (wr_done_i) begin
                    if (m_step == 32) begin m_phase = 3; m_done = 1; end
                    else begin m_step++; m_phase = 2; end
                end
                2: m_phase = 1;
                default: if (start_i) begin
                    m_phase = 0; m_cnt = 0; m_step = 0; m_done = 0;
                end
            endcase
        end
    end

    // Per-clock comparison, done-responder and write counter
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            int p;
            logic [11:0] ea;
            logic [7:0]  ed;
            check(m_phase == 0 ? "R1 req during settle" : "R7 req", wr_req_o, m_phase == 1);
            check("R9 init_done", init_done_o, m_done);
            if (m_phase == 1) begin
                check("R6 io space", wr_io_o, 1'b1);
                p = (m_step - 1) / 2;
                if (m_step == 0) begin
                    ea = 12'h3B8; ed = 8'h29;
                    check("R2 mode addr", wr_addr_o, ea);
                    check("R2 mode data", wr_data_o, ed);
                end else if ((m_step - 1) % 2 == 0) begin
                    check("R3 index addr", wr_addr_o, 12'h3B4);
                    check("R4 register number", wr_data_o, 15 - p);
                end else begin
                    check("R3 value addr", wr_addr_o, 12'h3B5);
                    check("R5 register value", wr_data_o, vals_desc[p]);
                end
            end
        end
        if (wr_req_o && !prev_req) writes++;
        prev_req = wr_req_o;
        if (wr_req_o) begin
            if (lat_cnt >= lat) wr_done_i = 1'b1;
            else begin wr_done_i = 1'b0; lat_cnt++; end
        end else begin
            wr_done_i = noise;  // R8: done while idle must be ignored
            lat_cnt = 0;
        end
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_init();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (init_done_o) return;
        end
        check("R9 completion timeout", 0, 1);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset req", wr_req_o, 0);
            check("R1 reset init_done", init_done_o, 0);
        end
        rst = 1'b0;
        lat = 0;
        wait_init();
        check("R6 write count run1", writes, 33);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R9 stays complete", init_done_o, 1);
        end

        lat = 2; noise = 1; writes = 0;
        pulse_start();
        check("R10 init_done dropped", init_done_o, 0);
        wait_init();
        check("R10 rerun write count", writes, 33);
        check("R8 idle done ignored count", writes, 33);

        lat = 1; noise = 0; writes = 0;
        pulse_start();
        for (int i = 0; i < 40; i++) @(negedge clk);
        check("R11 still running", init_done_o, 0);
        pulse_start();
        wait_init();
        check("R11 mid-run start ignored", writes, 33);

        lat = 3; writes = 0;
        pulse_start();
        wait_init();
        check("R6 write count slow", writes, 33);
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule